// File: doc/BRIEF.md
# CPU Interrupt Entry Controller

This block decides when a small 32-bit processor core leaves its instruction stream for an exception handler, and hands the core everything it needs for that switch. It accepts a reset request, a single non-maskable interrupt line and six maskable interrupt lines. The interrupt lines are edge-detected into sticky pending bits. The block holds the processor status word (PSW), the exception cause register and two pairs of save registers: one pair for the non-maskable path and one pair for the maskable path.

Each cycle the controller arbitrates among the pending requests against the current PSW flags. When a request wins, it produces a one-cycle entry event. On that event it captures the interrupted PC and PSW into the matching save pair, rewrites the PSW flags and the cause field, and presents the handler address for the core to load into its PC. A request that is blocked stays pending until the flags allow it. Two return strobes stand in for the return instructions: one clears the non-maskable-in-progress flag and the other clears the interrupt-disable flag.

Top module: `irq_entry_ctrl`

## Requirements
- R1: While `hw_reset_req` is high at a clock edge, the next cycle shows an entry with `entry_pc` = 0x0, PSW = 0x20 and cause register = 0. All pending requests are dropped, and this entry wins over every other request.
- R2: After the synchronous active-low `rst_n` the block shows `entry_valid` = 0, PSW = 0x20, cause register = 0 and all save registers = 0, with nothing pending.
- R3: A rising edge on `nmi_req` sets a single pending slot. While PSW bit 7 (NMI in progress) is set, that slot is held, and further rising edges add nothing, so at most one NMI entry follows.
- R4: An NMI entry copies `cur_pc` to `fepc_o` and the old PSW to `fepsw_o`. It sets PSW bits 7 and 5 (interrupt disable), clears bit 6 (exception in progress), writes 0x0010 into cause bits [31:16], keeps cause bits [15:0], and gives `entry_pc` = 0x10.
- R5: No maskable entry is taken while PSW bit 7 or bit 5 is set. Such requests stay pending until both bits are clear.
- R6: A maskable entry copies `cur_pc` to `eipc_o` and the old PSW to `eipsw_o`. It sets PSW bit 5, clears bit 6, leaves bit 7 unchanged, writes the vector into cause bits [15:0], and keeps bits [31:16].
- R7: Input `irq_req[i]` uses vector 0x80 + 0x10·i, which gives 0x80 to 0xD0 for bits 0 to 5.
- R8: The priority is reset, then NMI, then the lowest-numbered pending maskable line. At most one entry happens per cycle.
- R9: A maskable pending bit is set only by a 0→1 edge of its line. It is cleared only when its entry is taken, so a line held high does not request again.
- R10: `nmi_ret` clears PSW bit 7, and a held NMI is then taken on the following cycle. `int_ret` clears PSW bit 5. If an entry happens in the same cycle as a strobe, the entry's flag updates win.
- R11: Outputs are registered. A request edge seen at clock edge N can give an entry visible after edge N+1 at the earliest. `entry_valid` is a one-cycle pulse per entry, and `cause_we` pulses with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the block |
| hw_reset_req | input | 1 | Processor reset request (level) |
| nmi_req | input | 1 | Non-maskable interrupt line, edge-detected |
| irq_req | input | 6 | Maskable interrupt lines, edge-detected |
| cur_pc | input | 32 | PC of the interrupted instruction |
| nmi_ret | input | 1 | Return-from-NMI strobe, clears PSW bit 7 |
| int_ret | input | 1 | Return-from-interrupt strobe, clears PSW bit 5 |
| entry_valid | output | 1 | One-cycle entry pulse |
| entry_pc | output | 32 | Handler address to load into the PC |
| cause_we | output | 1 | Cause register write pulse |
| psw_o | output | 8 | Current PSW flags |
| ecr_o | output | 32 | Exception cause register |
| fepc_o | output | 32 | PC saved on NMI entry |
| fepsw_o | output | 8 | PSW saved on NMI entry |
| eipc_o | output | 32 | PC saved on maskable entry |
| eipsw_o | output | 8 | PSW saved on maskable entry |

## Verification
The hardest state to reach is a held NMI with a second NMI edge arriving on top of it, while maskable lines are also piling up behind both flags. The release order then decides what is taken. A directed sequence raises an NMI and two maskable lines in the same cycle. It pulses the NMI line twice more while the NMI flag is set, and releases the flags one strobe at a time, checking that exactly two NMI entries occur and that the maskable entries come out lowest line first. A long random phase follows with rare reset requests and frequent strobes and line toggles, compared each cycle against a bench model.

// File: rtl/irq_entry_pkg.sv
// Package: shared constants and types for the interrupt entry controller.
// Assumes an 8-bit PSW with the flag positions below; other bits pass through.
package irq_entry_pkg;
    localparam int PSW_W  = 8;
    localparam int ID_BIT = 5;   // interrupt disable
    localparam int EP_BIT = 6;   // exception in progress
    localparam int NP_BIT = 7;   // NMI in progress

    typedef enum logic [1:0] {
        ENT_NONE  = 2'd0,
        ENT_RESET = 2'd1,
        ENT_NMI   = 2'd2,
        ENT_MASK  = 2'd3
    } entry_kind_e;
endpackage

// File: rtl/irq_edge_pend.sv
// Module: edge detector with a sticky pending bit per line.
// A 0->1 edge sets the bit; a take clears it; clr_all drops every bit.
// Assumes the lines are already synchronous to clk.
module irq_edge_pend #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_all,
    input  logic [W-1:0] req_i,
    input  logic [W-1:0] take_i,
    output logic [W-1:0] pend_o
);
    logic [W-1:0] prev_q;

    for (genvar g = 0; g < W; g++) begin : g_line
        // Track the previous level and update the sticky pending bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prev_q[g] <= 1'b0;
                pend_o[g] <= 1'b0;
            end else begin
                prev_q[g] <= req_i[g];
                if (clr_all)
                    pend_o[g] <= 1'b0;
                else
                    pend_o[g] <= (pend_o[g] & ~take_i[g]) | (req_i[g] & ~prev_q[g]);
            end
        end
    end
endmodule

// File: rtl/irq_arbiter.sv
// Module: combinational priority and masking.
// Priority: reset, then NMI (blocked by NP), then the lowest pending
// maskable line (blocked by NP or ID). Grants at most one per cycle.
module irq_arbiter
    import irq_entry_pkg::*;
#(
    parameter int NUM_MASK = 6,
    localparam int IDX_W   = $clog2(NUM_MASK)
) (
    input  logic                hw_reset,
    input  logic                pend_nmi,
    input  logic [NUM_MASK-1:0] pend_mask,
    input  logic                np_flag,
    input  logic                id_flag,
    output entry_kind_e         kind,
    output logic                take_nmi,
    output logic [NUM_MASK-1:0] take_mask,
    output logic [IDX_W-1:0]    mask_idx
);
    logic             any_mask;
    logic [IDX_W-1:0] low_idx;

    // Find the lowest-numbered pending maskable line.
    always_comb begin
        low_idx  = '0;
        any_mask = 1'b0;
        for (int i = NUM_MASK - 1; i >= 0; i--) begin
            if (pend_mask[i]) begin
                low_idx  = IDX_W'(i);
                any_mask = 1'b1;
            end
        end
    end

    // Choose the winning entry kind and the one-hot take signals.
    always_comb begin
        kind      = ENT_NONE;
        take_nmi  = 1'b0;
        take_mask = '0;
        mask_idx  = low_idx;
        if (hw_reset) begin
            kind = ENT_RESET;
        end else if (pend_nmi && !np_flag) begin
            kind     = ENT_NMI;
            take_nmi = 1'b1;
        end else if (any_mask && !np_flag && !id_flag) begin
            kind               = ENT_MASK;
            take_mask[low_idx] = 1'b1;
        end
    end
endmodule

// File: rtl/irq_ctx_regs.sv
// Module: PSW, cause register, save registers and registered entry outputs.
// Assumes kind/mask_idx come from the arbiter in the same cycle.
module irq_ctx_regs
    import irq_entry_pkg::*;
#(
    parameter int                NUM_MASK  = 6,
    parameter int                XLEN      = 32,
    parameter logic [XLEN-1:0]   NMI_VEC   = 32'h10,
    parameter logic [XLEN-1:0]   VEC_BASE  = 32'h80,
    parameter logic [XLEN-1:0]   VEC_STEP  = 32'h10,
    parameter logic [PSW_W-1:0]  RESET_PSW = 8'h20,
    localparam int               IDX_W     = $clog2(NUM_MASK),
    localparam int               HALF_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  entry_kind_e       kind,
    input  logic [IDX_W-1:0]  mask_idx,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic              nmi_ret,
    input  logic              int_ret,
    output logic              entry_valid,
    output logic [XLEN-1:0]   entry_pc,
    output logic              cause_we,
    output logic [PSW_W-1:0]  psw_q,
    output logic [2*HALF_W-1:0] ecr_q,
    output logic [XLEN-1:0]   fepc_q,
    output logic [PSW_W-1:0]  fepsw_q,
    output logic [XLEN-1:0]   eipc_q,
    output logic [PSW_W-1:0]  eipsw_q
);
    logic [PSW_W-1:0] psw_ret;
    logic [XLEN-1:0]  mask_vec;

    // Apply the return strobes to the current PSW.
    always_comb begin
        psw_ret = psw_q;
        if (nmi_ret) psw_ret[NP_BIT] = 1'b0;
        if (int_ret) psw_ret[ID_BIT] = 1'b0;
    end

    // Compute the maskable handler address from the line index.
    always_comb mask_vec = VEC_BASE + XLEN'(mask_idx) * VEC_STEP;

    // Register the entry outputs and update the context state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            entry_valid <= 1'b0;
            entry_pc    <= '0;
            cause_we    <= 1'b0;
            psw_q       <= RESET_PSW;
            ecr_q       <= '0;
            fepc_q      <= '0;
            fepsw_q     <= '0;
            eipc_q      <= '0;
            eipsw_q     <= '0;
        end else begin
            entry_valid <= (kind != ENT_NONE);
            cause_we    <= (kind != ENT_NONE);
            unique case (kind)
                ENT_RESET: begin
                    entry_pc <= '0;
                    psw_q    <= RESET_PSW;
                    ecr_q    <= '0;
                end
                ENT_NMI: begin
                    fepc_q   <= cur_pc;
                    fepsw_q  <= psw_q;
                    psw_q    <= (psw_ret | (PSW_W'(1) << NP_BIT) | (PSW_W'(1) << ID_BIT))
                                & ~(PSW_W'(1) << EP_BIT);
                    ecr_q    <= {NMI_VEC[HALF_W-1:0], ecr_q[HALF_W-1:0]};
                    entry_pc <= NMI_VEC;
                end
                ENT_MASK: begin
                    eipc_q   <= cur_pc;
                    eipsw_q  <= psw_q;
                    psw_q    <= (psw_ret | (PSW_W'(1) << ID_BIT)) & ~(PSW_W'(1) << EP_BIT);
                    ecr_q    <= {ecr_q[2*HALF_W-1:HALF_W], mask_vec[HALF_W-1:0]};
                    entry_pc <= mask_vec;
                end
                default: psw_q <= psw_ret;
            endcase
        end
    end
endmodule

// File: rtl/irq_entry_ctrl.sv
// Module: top of the interrupt entry controller.
// Ties edge/pending capture, arbitration and context registers together.
// Assumes all inputs are synchronous to clk.
module irq_entry_ctrl
    import irq_entry_pkg::*;
#(
    parameter int               NUM_MASK  = 6,
    parameter int               XLEN      = 32,
    parameter logic [XLEN-1:0]  NMI_VEC   = 32'h10,
    parameter logic [XLEN-1:0]  VEC_BASE  = 32'h80,
    parameter logic [XLEN-1:0]  VEC_STEP  = 32'h10,
    parameter logic [PSW_W-1:0] RESET_PSW = 8'h20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hw_reset_req,
    input  logic                nmi_req,
    input  logic [NUM_MASK-1:0] irq_req,
    input  logic [XLEN-1:0]     cur_pc,
    input  logic                nmi_ret,
    input  logic                int_ret,
    output logic                entry_valid,
    output logic [XLEN-1:0]     entry_pc,
    output logic                cause_we,
    output logic [PSW_W-1:0]    psw_o,
    output logic [31:0]         ecr_o,
    output logic [XLEN-1:0]     fepc_o,
    output logic [PSW_W-1:0]    fepsw_o,
    output logic [XLEN-1:0]     eipc_o,
    output logic [PSW_W-1:0]    eipsw_o
);
    localparam int IDX_W = $clog2(NUM_MASK);

    entry_kind_e         ent_kind;
    logic                pend_nmi;
    logic [NUM_MASK-1:0] pend_mask;
    logic                take_nmi;
    logic [NUM_MASK-1:0] take_mask;
    logic [IDX_W-1:0]    mask_idx;

    irq_edge_pend #(.W(1)) u_nmi_pend (
        .clk(clk), .rst_n(rst_n), .clr_all(hw_reset_req),
        .req_i(nmi_req), .take_i(take_nmi), .pend_o(pend_nmi)
    );

    irq_edge_pend #(.W(NUM_MASK)) u_mask_pend (
        .clk(clk), .rst_n(rst_n), .clr_all(hw_reset_req),
        .req_i(irq_req), .take_i(take_mask), .pend_o(pend_mask)
    );

    irq_arbiter #(.NUM_MASK(NUM_MASK)) u_arb (
        .hw_reset(hw_reset_req), .pend_nmi(pend_nmi), .pend_mask(pend_mask),
        .np_flag(psw_o[NP_BIT]), .id_flag(psw_o[ID_BIT]),
        .kind(ent_kind), .take_nmi(take_nmi), .take_mask(take_mask),
        .mask_idx(mask_idx)
    );

    irq_ctx_regs #(
        .NUM_MASK(NUM_MASK), .XLEN(XLEN), .NMI_VEC(NMI_VEC),
        .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP), .RESET_PSW(RESET_PSW)
    ) u_ctx (
        .clk(clk), .rst_n(rst_n), .kind(ent_kind), .mask_idx(mask_idx),
        .cur_pc(cur_pc), .nmi_ret(nmi_ret), .int_ret(int_ret),
        .entry_valid(entry_valid), .entry_pc(entry_pc), .cause_we(cause_we),
        .psw_q(psw_o), .ecr_q(ecr_o), .fepc_q(fepc_o), .fepsw_q(fepsw_o),
        .eipc_q(eipc_o), .eipsw_q(eipsw_o)
    );
endmodule

// File: rtl/irq_entry_ctrl_chk.sv
// Module: assertion checker for irq_entry_ctrl, attached by bind.
// Assumes the default flag positions from irq_entry_pkg.
module irq_entry_ctrl_chk
    import irq_entry_pkg::*;
#(
    parameter int               NUM_MASK  = 6,
    parameter int               XLEN      = 32,
    parameter logic [XLEN-1:0]  NMI_VEC   = 32'h10,
    parameter logic [XLEN-1:0]  VEC_BASE  = 32'h80,
    parameter logic [PSW_W-1:0] RESET_PSW = 8'h20
) (
    input logic                clk,
    input logic                rst_n,
    input logic                hw_reset_req,
    input logic                take_nmi,
    input logic [NUM_MASK-1:0] take_mask,
    input logic                entry_valid,
    input logic [XLEN-1:0]     entry_pc,
    input logic                cause_we,
    input logic [PSW_W-1:0]    psw_o,
    input logic [31:0]         ecr_o
);
    // R8
    one_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({take_nmi, take_mask}));

    // R1
    reset_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hw_reset_req |=> (entry_valid && entry_pc == '0 && psw_o == RESET_PSW && ecr_o == '0));

    // R4
    nmi_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_valid && entry_pc == NMI_VEC) |->
        (psw_o[NP_BIT] && psw_o[ID_BIT] && !psw_o[EP_BIT] && ecr_o[31:16] == NMI_VEC[15:0]));

    // R5
    mask_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_valid && entry_pc >= VEC_BASE) |->
        (!$past(psw_o[NP_BIT]) && !$past(psw_o[ID_BIT])));

    // R6
    mask_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_valid && entry_pc >= VEC_BASE) |->
        (ecr_o[15:0] == entry_pc[15:0] && psw_o[ID_BIT] && !psw_o[EP_BIT]));

    // R11
    cause_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        entry_valid |-> cause_we);
endmodule

bind irq_entry_ctrl irq_entry_ctrl_chk #(
    .NUM_MASK(NUM_MASK), .XLEN(XLEN), .NMI_VEC(NMI_VEC),
    .VEC_BASE(VEC_BASE), .RESET_PSW(RESET_PSW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .hw_reset_req(hw_reset_req),
    .take_nmi(take_nmi), .take_mask(take_mask),
    .entry_valid(entry_valid), .entry_pc(entry_pc), .cause_we(cause_we),
    .psw_o(psw_o), .ecr_o(ecr_o)
);

// File: tb/tb_irq_entry_ctrl.sv
// Bench: directed corner cases then seeded random stimulus, each cycle
// compared against a model built from the requirements.
module tb_irq_entry_ctrl;
    localparam int NM = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hw_reset_req = 1'b0;
    logic          nmi_req = 1'b0;
    logic [NM-1:0] irq_req = '0;
    logic [31:0]   cur_pc = '0;
    logic          nmi_ret = 1'b0;
    logic          int_ret = 1'b0;
    logic          entry_valid, cause_we;
    logic [31:0]   entry_pc, ecr_o, fepc_o, eipc_o;
    logic [7:0]    psw_o, fepsw_o, eipsw_o;

    irq_entry_ctrl dut (
        .clk(clk), .rst_n(rst_n), .hw_reset_req(hw_reset_req), .nmi_req(nmi_req),
        .irq_req(irq_req), .cur_pc(cur_pc), .nmi_ret(nmi_ret), .int_ret(int_ret),
        .entry_valid(entry_valid), .entry_pc(entry_pc), .cause_we(cause_we),
        .psw_o(psw_o), .ecr_o(ecr_o), .fepc_o(fepc_o), .fepsw_o(fepsw_o),
        .eipc_o(eipc_o), .eipsw_o(eipsw_o)
    );

    always #5 clk = ~clk;

    int errors = 0;
    int checks = 0;
    int nmi_entries = 0;
    string cur_tag = "";

    // model state
    logic          m_ev, m_pn, m_pn_prev;
    logic [NM-1:0] m_pend, m_pi_prev;
    logic [31:0]   m_pc, m_ecr, m_fepc, m_eipc;
    logic [7:0]    m_psw, m_fepsw, m_eipsw;
    int            m_kind;   // 0 none, 1 reset, 2 nmi, 3 maskable

    function automatic logic [31:0] vec_of(int i);
        return 32'h80 + 32'h10 * i;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Advance the model by one clock edge from the requirements.
    task automatic model_step();
        logic          rise_n;
        logic [NM-1:0] rise_i, take_i;
        logic          take_n;
        logic [7:0]    pr;
        int            idx;
        if (!rst_n) begin
            m_ev = 0; m_pn = 0; m_pn_prev = 0; m_pend = '0; m_pi_prev = '0;
            m_pc = '0; m_ecr = '0; m_fepc = '0; m_eipc = '0;
            m_psw = 8'h20; m_fepsw = '0; m_eipsw = '0; m_kind = 0;
            return;
        end
        rise_n = nmi_req & ~m_pn_prev;
        rise_i = irq_req & ~m_pi_prev;
        m_pn_prev = nmi_req;
        m_pi_prev = irq_req;
        take_n = 0; take_i = '0; m_ev = 0; m_kind = 0;
        if (hw_reset_req) begin
            m_ev = 1; m_kind = 1; m_pc = '0; m_psw = 8'h20; m_ecr = '0;
            m_pn = 0; m_pend = '0;
        end else begin
            pr = m_psw;
            if (nmi_ret) pr[7] = 1'b0;
            if (int_ret) pr[5] = 1'b0;
            if (m_pn && !m_psw[7]) begin
                m_ev = 1; m_kind = 2; take_n = 1;
                m_fepc = cur_pc; m_fepsw = m_psw;
                m_psw = (pr | 8'hA0) & ~8'h40;
                m_ecr = {16'h0010, m_ecr[15:0]};
                m_pc = 32'h10;
            end else if (!m_psw[7] && !m_psw[5] && m_pend != '0) begin
                idx = 0;
                for (int i = NM - 1; i >= 0; i--) if (m_pend[i]) idx = i;
                m_ev = 1; m_kind = 3; take_i[idx] = 1'b1;
                m_eipc = cur_pc; m_eipsw = m_psw;
                m_psw = (pr | 8'h20) & ~8'h40;
                m_ecr = {m_ecr[31:16], vec_of(idx)[15:0]};
                m_pc = vec_of(idx);
            end else begin
                m_psw = pr;
            end
            m_pn = (m_pn & ~take_n) | rise_n;
            m_pend = (m_pend & ~take_i) | rise_i;
        end
    endtask

    // Compare every output with the model, tagged by phase or event.
    task automatic compare();
        string t, tp;
        if (cur_tag != "") begin
            t = cur_tag; tp = cur_tag;
        end else begin
            case (m_kind)
                1: begin t = "R1"; tp = "R1"; end
                2: begin t = "R4"; tp = "R4"; end
                3: begin t = "R6"; tp = "R7"; end
                default: begin t = "R5"; tp = "R5"; end
            endcase
        end
        if (entry_valid && entry_pc == 32'h10) nmi_entries++;
        check("R11", {31'b0, entry_valid}, {31'b0, m_ev}, "entry_valid");
        check("R11", {31'b0, cause_we}, {31'b0, m_ev}, "cause_we");
        check(tp, entry_pc, m_pc, "entry_pc");
        check(t, {24'b0, psw_o}, {24'b0, m_psw}, "psw");
        check(t, ecr_o, m_ecr, "ecr");
        check(t, fepc_o, m_fepc, "fepc");
        check(t, {24'b0, fepsw_o}, {24'b0, m_fepsw}, "fepsw");
        check(t, eipc_o, m_eipc, "eipc");
        check(t, {24'b0, eipsw_o}, {24'b0, m_eipsw}, "eipsw");
    endtask

    task automatic step();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
        nmi_ret = 1'b0;
        int_ret = 1'b0;
        cur_pc  = $urandom;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h1357_2468));
        // R2: block reset state
        cur_tag = "R2";
        step(); step();
        rst_n = 1'b1;
        step();
        // R1: reset request with a simultaneous NMI edge, which is dropped
        cur_tag = "R1";
        hw_reset_req = 1'b1; nmi_req = 1'b1;
        step();
        hw_reset_req = 1'b0;
        cur_tag = "R9";
        step(); step();
        nmi_req = 1'b0;
        // R10: int_ret clears ID
        cur_tag = "R10";
        int_ret = 1'b1;
        step();
        // R8: NMI and two maskable lines rise together
        cur_tag = "R8";
        nmi_entries = 0;
        nmi_req = 1'b1; irq_req = 6'b001010;
        step(); step();
        // R3: more NMI edges while NP is set collapse into one
        cur_tag = "R3";
        nmi_req = 1'b0; step();
        nmi_req = 1'b1; step();
        nmi_req = 1'b0; step();
        nmi_req = 1'b1; step();
        // R5: maskable lines still blocked
        cur_tag = "R5";
        step(); step();
        // R10: release NP, held NMI taken next cycle
        cur_tag = "R10";
        nmi_ret = 1'b1; step(); step(); step();
        check("R3", nmi_entries, 2, "nmi entry count");
        nmi_ret = 1'b1; step();
        int_ret = 1'b1; step();
        // R7: line 1 first (0x90), then line 3 after ID release
        cur_tag = "R7";
        step(); step();
        check("R7", entry_pc, 32'h90, "first maskable vector");
        int_ret = 1'b1; step(); step();
        check("R7", entry_pc, 32'hB0, "second maskable vector");
        // R9: lines still high, no new request after ID release
        cur_tag = "R9";
        int_ret = 1'b1; step(); step(); step();
        irq_req = '0; nmi_req = 1'b0;
        step();
        // random phase
        cur_tag = "";
        for (int n = 0; n < 4000; n++) begin
            hw_reset_req = ($urandom_range(0, 199) == 0);
            if ($urandom_range(0, 9) == 0) nmi_req = ~nmi_req;
            for (int b = 0; b < NM; b++)
                if ($urandom_range(0, 5) == 0) irq_req[b] = ~irq_req[b];
            step();
            nmi_ret = ($urandom_range(0, 14) == 0);
            int_ret = ($urandom_range(0, 5) == 0);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule